// File: doc/BRIEF.md
# Fault-Remapping Cache Index Decoder

This block is a small direct-mapped cache whose set decoder can be reprogrammed at run time. Each physical line has a fault flag. When a line is marked faulty, the decoder sends the traffic for that line to a healthy partner line. The partners form a binary tree of nested groups: lines in pairs, pairs in quads, quads in the full array. At each level, when the preferred group is entirely faulty, the access moves to the sibling group. An access is refused outright only when every line is faulty. Because a remap merges two index values onto one line, the index bits the decoder consumed are kept next to the address tag. The bits of the levels where merging happens take part in the compare, so data filled for one index can never answer a lookup for its merged partner.

An option feeds the index bits to the decoder levels in reversed order. The bit that picks the line within a pair is then the most significant index bit, so two indices that share a line sit far apart in the address space. The fault flags and the order option are held in a configuration register. Every write to that register invalidates the whole cache, since the old contents no longer match the new mapping.

Requests enter on a valid/ready channel and are either lookups or fills. Each request produces one response on a valid/ready output channel. The response carries the physical line that was used, the mask of merged levels, a forced-miss flag, and the pre-access hit status and data. The upstream side may present a request at any time. A request is taken only in a cycle where `req_ready` is high. `req_ready` is high when no response is pending or when the pending response is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.

Top module: `fault_remap_cache`

## Requirements
- R1: With no fault flags set and normal order, index i (address bits [2:0]) selects physical line i. A lookup hits, returning the filled data, only when both the tag (address bits [7:3]) and the index match a prior fill.
- R2: If one line of a pair {2k, 2k+1} is faulty, both index values of that pair use the healthy line, and `rsp_xmask` bit 0 is set for accesses to that line.
- R3: A lookup whose tag matches the data on its line, but whose index bit at a merged level differs from the stored one, is a miss. A fill to a merged line replaces the data of its partner index.
- R4: If every line of a group at level k (k=1: pair, k=2: quad) is faulty, accesses aimed at that group go to its sibling group, and `rsp_xmask` bit k is set. Indices that differ only in that bit are told apart.
- R5: With the reverse option set, decoder level k uses index bit (2-k), so index 0 and index 4 share a line when line 0 is faulty.
- R6: A non-forced access never selects a line whose fault flag is set. Lines that no fault affects keep their normal mapping and contents, so an 8-line cache with one fault behaves as a 7-line cache.
- R7: When all 8 lines are faulty, every response has `rsp_nomap`=1 and `rsp_hit`=0, and fills store nothing.
- R8: At most one response is outstanding. `req_ready` = !`rsp_valid` || `rsp_ready`. Response fields are stable while stalled.
- R9: A configuration write invalidates every line. A fill accepted in the same cycle as a configuration write is discarded.
- R10: After reset no response is pending, `req_ready` is 1, all lines are invalid, no faults are set and the order is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load fault flags and order option; invalidates all lines |
| cfg_fault | input | 8 | Per-line fault flags, bit n for physical line n |
| cfg_rev | input | 1 | 1 = index bits fed to decoder levels in reversed order |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| req_fill | input | 1 | 1 = fill (write tag and data), 0 = lookup |
| req_addr | input | 8 | Address: tag in [7:3], index in [2:0] |
| req_data | input | 8 | Fill data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_hit | output | 1 | Hit status before the access |
| rsp_nomap | output | 1 | Forced miss: no healthy line available |
| rsp_line | output | 3 | Physical line used |
| rsp_xmask | output | 3 | Levels whose index bit is compared in the extended tag |
| rsp_data | output | 8 | Line data on hit, zero on miss |

## Verification
Two functions can coincide in one cycle: acceptance of a fill request, and a configuration write that clears all valid bits. The bench drives `cfg_we` in the same cycle in which a fill is accepted. It then looks up the same address and expects a miss, showing that invalidation wins over the write. A second overlap is a response stall coinciding with a new request. The bench toggles `rsp_ready` in a repeating pattern while requests are queued, and checks that `req_ready` follows the stall and that the stalled fields do not move.

// File: rtl/fault_remap_pkg.sv
package fault_remap_pkg;
  localparam int unsigned DEF_IDX_W  = 3;
  localparam int unsigned DEF_TAG_W  = 5;
  localparam int unsigned DEF_DATA_W = 8;

  typedef enum logic {
    OP_LOOKUP = 1'b0,
    OP_FILL   = 1'b1
  } op_e;
endpackage

// File: rtl/fault_remap_decoder.sv
module fault_remap_decoder #(
  parameter int unsigned IDX_W = 3,
  localparam int unsigned LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [LINES-1:0] fault,
  input  logic             rev,
  output logic [IDX_W-1:0] ord_idx,
  output logic [IDX_W-1:0] line,
  output logic [IDX_W-1:0] xmask,
  output logic             nomap
);
  logic [IDX_W-1:0] rv_idx;
  logic [IDX_W:0][LINES-1:0] grp_dead;

  for (genvar b = 0; b < IDX_W; b++) begin : g_rev
    assign rv_idx[b] = idx[IDX_W-1-b];
  end
  assign ord_idx = rev ? rv_idx : idx;

  assign grp_dead[0] = fault;
  for (genvar lv = 0; lv < IDX_W; lv++) begin : g_lvl
    for (genvar j = 0; j < LINES; j++) begin : g_grp
      if (j < (LINES >> (lv + 1))) begin : g_real
        assign grp_dead[lv+1][j] = grp_dead[lv][2*j] & grp_dead[lv][2*j+1];
      end else begin : g_pad
        assign grp_dead[lv+1][j] = 1'b0;
      end
    end
  end
  assign nomap = grp_dead[IDX_W][0];

  always_comb begin
    logic [IDX_W-1:0] pre;
    logic [IDX_W-1:0] cand;
    pre   = '0;
    cand  = '0;
    xmask = '0;
    for (int k = IDX_W - 1; k >= 0; k--) begin
      cand = (pre << 1) | IDX_W'(ord_idx[k]);
      if (grp_dead[k][cand]) cand = cand ^ IDX_W'(1);
      xmask[k] = grp_dead[k][cand ^ IDX_W'(1)];
      pre = cand;
    end
    line = pre;
  end

  // R1
  identity_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == '0 && !rev) |-> (line == idx && xmask == '0));
  // R6
  healthy_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nomap |-> !fault[line]);
  // R7
  forced_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nomap |-> (&fault));
endmodule

// File: rtl/fault_remap_store.sv
module fault_remap_store #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned TAG_W  = 5,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  line,
  input  logic [TAG_W-1:0]  tag,
  input  logic [IDX_W-1:0]  ord_idx,
  input  logic [IDX_W-1:0]  xmask,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data
);
  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [IDX_W-1:0]  xidx_q [LINES];
  logic [DATA_W-1:0] dat_q  [LINES];

  for (genvar n = 0; n < LINES; n++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[n]  <= 1'b0;
        tag_q[n]  <= '0;
        xidx_q[n] <= '0;
        dat_q[n]  <= '0;
      end else if (clr) begin
        vld_q[n] <= 1'b0;
      end else if (wr_en && line == IDX_W'(n)) begin
        vld_q[n]  <= 1'b1;
        tag_q[n]  <= tag;
        xidx_q[n] <= ord_idx;
        dat_q[n]  <= wr_data;
      end
    end
  end

  assign hit = vld_q[line] && (tag_q[line] == tag)
               && (((xidx_q[line] ^ ord_idx) & xmask) == '0);
  assign rd_data = hit ? dat_q[line] : '0;

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));
endmodule

// File: rtl/fault_remap_cache.sv
module fault_remap_cache #(
  parameter int unsigned IDX_W  = fault_remap_pkg::DEF_IDX_W,
  parameter int unsigned TAG_W  = fault_remap_pkg::DEF_TAG_W,
  parameter int unsigned DATA_W = fault_remap_pkg::DEF_DATA_W,
  localparam int unsigned LINES  = 1 << IDX_W,
  localparam int unsigned ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [LINES-1:0]  cfg_fault,
  input  logic              cfg_rev,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_fill,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_nomap,
  output logic [IDX_W-1:0]  rsp_line,
  output logic [IDX_W-1:0]  rsp_xmask,
  output logic [DATA_W-1:0] rsp_data
);
  import fault_remap_pkg::*;

  logic [LINES-1:0]  fault_q;
  logic              rev_q;
  logic [IDX_W-1:0]  ord_idx, dec_line, dec_mask;
  logic              dec_nomap, st_hit, accept;
  logic [DATA_W-1:0] st_data;
  op_e               op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
      rev_q   <= 1'b0;
    end else if (cfg_we) begin
      fault_q <= cfg_fault;
      rev_q   <= cfg_rev;
    end
  end

  assign op        = req_fill ? OP_FILL : OP_LOOKUP;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  fault_remap_decoder #(.IDX_W(IDX_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (req_addr[IDX_W-1:0]),
    .fault   (fault_q),
    .rev     (rev_q),
    .ord_idx (ord_idx),
    .line    (dec_line),
    .xmask   (dec_mask),
    .nomap   (dec_nomap)
  );

  fault_remap_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cfg_we),
    .wr_en   (accept && op == OP_FILL && !dec_nomap),
    .line    (dec_line),
    .tag     (req_addr[ADDR_W-1:IDX_W]),
    .ord_idx (ord_idx),
    .xmask   (dec_mask),
    .wr_data (req_data),
    .hit     (st_hit),
    .rd_data (st_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_nomap <= 1'b0;
      rsp_line  <= '0;
      rsp_xmask <= '0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= st_hit && !dec_nomap;
      rsp_nomap <= dec_nomap;
      rsp_line  <= dec_line;
      rsp_xmask <= dec_mask;
      rsp_data  <= dec_nomap ? '0 : st_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_line)
      && $stable(rsp_data) && $stable(rsp_xmask) && $stable(rsp_nomap)));
  // R7
  nomap_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nomap) |-> !rsp_hit);
endmodule

// File: tb/fault_remap_cache_tb_top.sv
`timescale 1ns/100ps
module fault_remap_cache_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_fault = '0;
  logic       cfg_rev = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_fill = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic       rsp_hit, rsp_nomap;
  logic [2:0] rsp_line, rsp_xmask;
  logic [7:0] rsp_data;

  always #2 clk = ~clk;

  fault_remap_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fault(cfg_fault), .cfg_rev(cfg_rev),
    .req_valid(req_valid), .req_ready(req_ready), .req_fill(req_fill),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_nomap(rsp_nomap), .rsp_line(rsp_line),
    .rsp_xmask(rsp_xmask), .rsp_data(rsp_data)
  );

  typedef struct {
    logic       hit;
    logic [7:0] data;
    logic [2:0] line;
    logic [2:0] mask;
    logic       nomap;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   bp_mode = 1'b0;
  bit   done = 1'b0;
  int   cyc = 0;

  task automatic report(bit ok, string req, string act, string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // driver: pushes the expected response, then presents the request
  task automatic issue(bit fill, logic [7:0] addr, logic [7:0] data,
                       bit e_hit, logic [7:0] e_data, logic [2:0] e_line,
                       logic [2:0] e_mask, bit e_nomap, string req,
                       bit with_cfg = 1'b0, logic [7:0] c_f = '0, bit c_r = 1'b0);
    exp_t e;
    e.hit = e_hit; e.data = e_data; e.line = e_line;
    e.mask = e_mask; e.nomap = e_nomap; e.req = req;
    @(negedge clk);
    exp_q.push_back(e);
    req_valid = 1'b1; req_fill = fill; req_addr = addr; req_data = data;
    if (with_cfg) begin
      cfg_we = 1'b1; cfg_fault = c_f; cfg_rev = c_r;
    end
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    cfg_we = 1'b0;
  endtask

  task automatic cfg(logic [7:0] f, bit r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fault = f; cfg_rev = r;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: sets ready after each edge, compares at the falling edge
  initial begin
    bit held = 1'b0;
    logic [18:0] snap = '0;
    forever begin
      @(posedge clk);
      #1;
      rsp_ready = bp_mode ? ((cyc % 3) != 2) : 1'b1;
      @(negedge clk);
      if (rsp_valid) begin
        if (held)
          report({rsp_hit, rsp_nomap, rsp_line, rsp_xmask, rsp_data} == snap, "R8 stall hold",
                 $sformatf("%h", {rsp_hit, rsp_nomap, rsp_line, rsp_xmask, rsp_data}),
                 $sformatf("%h", snap));
        if (rsp_ready) begin
          exp_t e;
          held = 1'b0;
          if (exp_q.size() == 0) begin
            report(1'b0, "R8 unexpected response", "resp", "none");
          end else begin
            bit ok;
            e = exp_q.pop_front();
            ok = (rsp_hit == e.hit) && (rsp_nomap == e.nomap) && (rsp_data == e.data);
            if (!e.nomap) ok = ok && (rsp_line == e.line) && (rsp_xmask == e.mask);
            report(ok, e.req,
                   $sformatf("hit=%0b nomap=%0b line=%0d mask=%b data=%h",
                             rsp_hit, rsp_nomap, rsp_line, rsp_xmask, rsp_data),
                   $sformatf("hit=%0b nomap=%0b line=%0d mask=%b data=%h",
                             e.hit, e.nomap, e.line, e.mask, e.data));
          end
        end else begin
          held = 1'b1;
          snap = {rsp_hit, rsp_nomap, rsp_line, rsp_xmask, rsp_data};
          report(req_ready == 1'b0, "R8 ready under stall", $sformatf("%0b", req_ready), "0");
        end
      end else begin
        held = 1'b0;
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      report(1'b0, "watchdog", "timeout", "completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    report(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 idle in reset",
           $sformatf("v=%0b r=%0b", rsp_valid, req_ready), "v=0 r=1");
    rst_n = 1'b1;
    // R10: empty after reset, identity mapping
    issue(0, 8'h00, 8'h00, 0, 8'h00, 3'd0, 3'b000, 0, "R10 miss after reset");
    // R1: no faults
    issue(1, 8'h13, 8'hA5, 0, 8'h00, 3'd3, 3'b000, 0, "R1 fill idx3");
    issue(0, 8'h13, 8'h00, 1, 8'hA5, 3'd3, 3'b000, 0, "R1 hit idx3");
    issue(0, 8'h0B, 8'h00, 0, 8'h00, 3'd3, 3'b000, 0, "R1 tag mismatch");
    issue(1, 8'h05, 8'h5C, 0, 8'h00, 3'd5, 3'b000, 0, "R1 fill idx5");
    issue(0, 8'h05, 8'h00, 1, 8'h5C, 3'd5, 3'b000, 0, "R1 hit idx5");
    // line 0 faulty
    cfg(8'h01, 1'b0);
    issue(0, 8'h13, 8'h00, 0, 8'h00, 3'd3, 3'b000, 0, "R9 invalidated by cfg");
    issue(1, 8'h00, 8'h11, 0, 8'h00, 3'd1, 3'b001, 0, "R2 idx0 to line1");
    issue(0, 8'h00, 8'h00, 1, 8'h11, 3'd1, 3'b001, 0, "R2 hit remapped");
    issue(0, 8'h01, 8'h00, 0, 8'h00, 3'd1, 3'b001, 0, "R3 no false hit");
    issue(1, 8'h01, 8'h22, 0, 8'h00, 3'd1, 3'b001, 0, "R3 fill partner");
    issue(0, 8'h00, 8'h00, 0, 8'h00, 3'd1, 3'b001, 0, "R3 partner replaced");
    issue(0, 8'h01, 8'h00, 1, 8'h22, 3'd1, 3'b001, 0, "R3 partner hit");
    issue(1, 8'h06, 8'h66, 0, 8'h00, 3'd6, 3'b000, 0, "R6 unaffected fill");
    issue(0, 8'h06, 8'h00, 1, 8'h66, 3'd6, 3'b000, 0, "R6 unaffected hit");
    // lower quad faulty
    cfg(8'h0F, 1'b0);
    issue(1, 8'h00, 8'h33, 0, 8'h00, 3'd4, 3'b100, 0, "R4 quad remap fill");
    issue(0, 8'h04, 8'h00, 0, 8'h00, 3'd4, 3'b100, 0, "R4 no false hit idx4");
    issue(0, 8'h00, 8'h00, 1, 8'h33, 3'd4, 3'b100, 0, "R4 hit idx0");
    issue(0, 8'h02, 8'h00, 0, 8'h00, 3'd6, 3'b100, 0, "R4 idx2 to line6");
    // reversed order, line 0 faulty
    cfg(8'h01, 1'b1);
    issue(1, 8'h04, 8'h44, 0, 8'h00, 3'd1, 3'b001, 0, "R5 idx4 to line1");
    issue(0, 8'h00, 8'h00, 0, 8'h00, 3'd1, 3'b001, 0, "R5 idx0 shares line1");
    issue(0, 8'h04, 8'h00, 1, 8'h44, 3'd1, 3'b001, 0, "R5 hit idx4");
    issue(0, 8'h01, 8'h00, 0, 8'h00, 3'd4, 3'b000, 0, "R5 idx1 to line4");
    // everything faulty
    cfg(8'hFF, 1'b0);
    issue(0, 8'h00, 8'h00, 0, 8'h00, 3'd0, 3'b000, 1, "R7 forced miss");
    issue(1, 8'h03, 8'h77, 0, 8'h00, 3'd0, 3'b000, 1, "R7 fill refused");
    issue(0, 8'h03, 8'h00, 0, 8'h00, 3'd0, 3'b000, 1, "R7 still miss");
    // back-pressure
    cfg(8'h00, 1'b0);
    bp_mode = 1'b1;
    issue(0, 8'h03, 8'h00, 0, 8'h00, 3'd3, 3'b000, 0, "R7 nothing stored");
    issue(1, 8'h17, 8'h77, 0, 8'h00, 3'd7, 3'b000, 0, "R8 fill under bp");
    issue(0, 8'h17, 8'h00, 1, 8'h77, 3'd7, 3'b000, 0, "R8 hit under bp");
    issue(1, 8'h12, 8'h12, 0, 8'h00, 3'd2, 3'b000, 0, "R8 fill2 under bp");
    issue(0, 8'h12, 8'h00, 1, 8'h12, 3'd2, 3'b000, 0, "R8 hit2 under bp");
    issue(0, 8'h17, 8'h00, 1, 8'h77, 3'd7, 3'b000, 0, "R8 rehit under bp");
    while (exp_q.size() != 0) @(negedge clk);
    bp_mode = 1'b0;
    repeat (2) @(negedge clk);
    // fill and configuration write in one cycle
    issue(1, 8'h02, 8'h99, 0, 8'h00, 3'd2, 3'b000, 0, "R9 fill with cfg", 1'b1, 8'h00, 1'b0);
    issue(0, 8'h02, 8'h00, 0, 8'h00, 3'd2, 3'b000, 0, "R9 same-cycle fill dropped");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule